// File: doc/BRIEF.md
# Quadrature Encoder Times-Four Position Decoder

This block turns the two quadrature channels of an incremental rotary encoder, plus its once-per-revolution index line, into a signed-free up/down position word. Each raw input first crosses into the clock domain through a two-stage flip-flop chain. A debounce filter then accepts a new level only after it has held for a set number of clocks. A four-state Mealy phase tracker compares the filtered channel pair with the last accepted phase and decides whether to step up, step down, or flag an impossible jump.

The counter moves on every edge of either channel, so one full period of a channel gives four counts. A 50-line encoder therefore gives 200 counts per turn, which fits the default 8-bit position word. The rising edge of the filtered index line loads the position with zero, so the index acts as an absolute reference once per turn. Each counted step comes with a one-clock strobe and a direction bit. A step where both channels change together is not counted and sets a sticky error flag.

Top module: `qdec_x4_top`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears pos to 0, dir to 0, step_valid to 0 and jump_err to 0, and makes the tracked phase 00.
- R2: The phase is the pair {A,B} with A as the upper bit. Each move along 00→01→11→10→00 adds one to pos.
- R3: Each move along the reverse order 00→10→11→01→00 subtracts one from pos.
- R4: One full period of the channels, four phase moves, changes pos by exactly four.
- R5: Every counted step raises step_valid for exactly one clock, with dir at 1 for an up step and 0 for a down step. dir holds its value between steps.
- R6: When both filtered channels change at the same clock, pos does not change, no strobe is raised, and jump_err goes to 1 and stays there until reset.
- R7: A rising edge of the filtered index loads pos with 0. An index held high, or its falling edge, does not change pos.
- R8: A raw input level that lasts fewer than DEB_CYCLES clocks after synchronization is ignored. pos stays the same and no strobe is raised.
- R9: pos wraps modulo 2^POS_W: stepping down from 0 gives all ones, and stepping up from all ones gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_a | input | 1 | Raw quadrature channel A, asynchronous |
| enc_b | input | 1 | Raw quadrature channel B, asynchronous |
| enc_idx | input | 1 | Raw once-per-turn index, asynchronous |
| pos | output | POS_W | Position count |
| dir | output | 1 | Direction of the last counted step, 1 = up |
| step_valid | output | 1 | One-clock strobe per counted step |
| jump_err | output | 1 | Sticky flag for a two-channel jump |

## Verification
The bench drives both rotation orders over full periods and crosses zero in each direction. A design with the phase order swapped would count the wrong way, and one with a faulty wrap would show the wrong value after 0 or all ones. It pulses the index and then holds it high while the channels move. A level-sensitive zero would pin the count at 0, and a falling-edge zero would clear it when the index drops. A short glitch on a channel catches a filter that lets short pulses through. A simultaneous change of both channels catches a tracker that counts a jump, or an error flag that clears itself on the next good step.

// File: rtl/qdec_pkg.sv
// qdec_pkg: shared phase type and phase-order helpers for the decoder.
// Assumes the phase is the pair {A,B} with A as the upper bit.
package qdec_pkg;

    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_11 = 2'b11,
        PH_10 = 2'b10
    } phase_e;

    // Phase reached by one forward (count-up) move.
    function automatic phase_e phase_fwd(input phase_e p);
        case (p)
            PH_00:   return PH_01;
            PH_01:   return PH_11;
            PH_11:   return PH_10;
            default: return PH_00;
        endcase
    endfunction

    // Phase reached by one backward (count-down) move.
    function automatic phase_e phase_bwd(input phase_e p);
        case (p)
            PH_00:   return PH_10;
            PH_10:   return PH_11;
            PH_11:   return PH_01;
            default: return PH_00;
        endcase
    endfunction

endpackage

// File: rtl/qdec_input_cond.sv
// qdec_input_cond: brings one asynchronous encoder line into the clock
// domain through a flip-flop chain, then filters it so that a new level is
// taken only after it has held for DEB_CYCLES consecutive clocks.
// Assumes SYNC_STAGES >= 2 and DEB_CYCLES >= 1; the output resets to 0.
module qdec_input_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYCLES  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean_out
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          hold_cnt_q;
    logic                   level_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
    end

    // Accept the synchronized level once it has differed for DEB_CYCLES clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q    <= 1'b0;
            hold_cnt_q <= '0;
        end else if (synced == level_q) begin
            hold_cnt_q <= '0;
        end else if (hold_cnt_q == CW'(DEB_CYCLES - 1)) begin
            level_q    <= synced;
            hold_cnt_q <= '0;
        end else begin
            hold_cnt_q <= hold_cnt_q + CW'(1);
        end
    end

    assign clean_out = level_q;

    // R8: the filtered level only ever moves toward the synchronized level.
    assert_filter_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> ($past(synced) == level_q));

endmodule

// File: rtl/qdec_phase_fsm.sv
// qdec_phase_fsm: Mealy phase tracker. It holds the last accepted {A,B}
// phase and compares it with the incoming filtered pair. The up, down and
// jump outputs depend on both the state and the new input.
// Assumes the filtered inputs read 00 right after reset.
module qdec_phase_fsm
    import qdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] phase_in,
    output logic       step_up,
    output logic       step_dn,
    output logic       jump
);
    phase_e state_q;
    phase_e in_ph;

    assign in_ph = phase_e'(phase_in);

    // Classify the move from the stored phase to the incoming one.
    always_comb begin
        step_up = (in_ph == phase_fwd(state_q));
        step_dn = (in_ph == phase_bwd(state_q));
        jump    = (in_ph != state_q) && !step_up && !step_dn;
    end

    // Track the incoming phase every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_00;
        else        state_q <= in_ph;
    end

    // R2: an up or down move changes exactly one channel.
    assert_single_bit_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up || step_dn) |-> ($countones(phase_in ^ state_q) == 1));

    // R6: at most one classification per clock.
    assert_one_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn, jump}));

endmodule

// File: rtl/qdec_counter.sv
// qdec_counter: position register with index zeroing, step strobe,
// direction bit and sticky jump flag. Index rising edge takes priority
// over a step in the same clock. The position wraps modulo 2^POS_W.
module qdec_counter #(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic             jump,
    input  logic             idx_level,
    output logic [POS_W-1:0] pos,
    output logic             dir,
    output logic             step_valid,
    output logic             jump_err
);
    logic [POS_W-1:0] pos_q;
    logic             idx_q;
    logic             dir_q;
    logic             strobe_q;
    logic             err_q;
    logic             idx_rise;

    assign idx_rise = idx_level && !idx_q;

    // Remember the index level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= 1'b0;
        else        idx_q <= idx_level;
    end

    // Update position: index zero first, then up or down.
    always_ff @(posedge clk) begin
        if (!rst_n)        pos_q <= '0;
        else if (idx_rise) pos_q <= '0;
        else if (step_up)  pos_q <= pos_q + POS_W'(1);
        else if (step_dn)  pos_q <= pos_q - POS_W'(1);
    end

    // Strobe, direction and sticky jump flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            dir_q    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            strobe_q <= step_up || step_dn;
            if (step_up || step_dn) dir_q <= step_up;
            if (jump)               err_q <= 1'b1;
        end
    end

    assign pos        = pos_q;
    assign dir        = dir_q;
    assign step_valid = strobe_q;
    assign jump_err   = err_q;

    assert_up_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_q && dir_q && !$past(idx_rise)) |-> (pos_q == $past(pos_q) + POS_W'(1)));

    assert_down_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_q && !dir_q && !$past(idx_rise)) |-> (pos_q == $past(pos_q) - POS_W'(1)));

    assert_index_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(idx_rise) |-> (pos_q == '0));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    assert_jump_no_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> !strobe_q);

endmodule

// File: rtl/qdec_x4_top.sv
// qdec_x4_top: quadrature encoder decoder with four counts per channel
// period. Three conditioned inputs (B, A, index) feed a Mealy phase tracker
// and a position counter. Assumes the encoder is at phase 00 during reset.
module qdec_x4_top #(
    parameter int POS_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYCLES  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_idx,
    output logic [POS_W-1:0] pos,
    output logic             dir,
    output logic             step_valid,
    output logic             jump_err
);
    localparam int N_LINES = 3;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] clean_lines;
    logic               up, dn, jmp;

    assign raw_lines = {enc_idx, enc_a, enc_b};

    // One conditioner per input line.
    for (genvar i = 0; i < N_LINES; i++) begin : g_cond
        qdec_input_cond #(
            .SYNC_STAGES(SYNC_STAGES),
            .DEB_CYCLES (DEB_CYCLES)
        ) u_cond (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (raw_lines[i]),
            .clean_out(clean_lines[i])
        );
    end

    qdec_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_in(clean_lines[1:0]),
        .step_up (up),
        .step_dn (dn),
        .jump    (jmp)
    );

    qdec_counter #(.POS_W(POS_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_up   (up),
        .step_dn   (dn),
        .jump      (jmp),
        .idx_level (clean_lines[2]),
        .pos       (pos),
        .dir       (dir),
        .step_valid(step_valid),
        .jump_err  (jump_err)
    );

endmodule

// File: tb/tb_qdec_x4_top.sv
module tb_qdec_x4_top;
    localparam int POS_W  = 8;
    localparam int DEB    = 4;
    localparam int SETTLE = 16;
    localparam int NV     = 15;

    // Vector: {ab[1:0], idx, pos[7:0], dir, strobes[2:0]}
    localparam logic [14:0] VEC [NV] = '{
        {2'b01, 1'b0, 8'd1,   1'b1, 3'd1},  // R2
        {2'b11, 1'b0, 8'd2,   1'b1, 3'd1},  // R2
        {2'b10, 1'b0, 8'd3,   1'b1, 3'd1},  // R2
        {2'b00, 1'b0, 8'd4,   1'b1, 3'd1},  // R4
        {2'b10, 1'b0, 8'd3,   1'b0, 3'd1},  // R3
        {2'b11, 1'b0, 8'd2,   1'b0, 3'd1},  // R3
        {2'b01, 1'b0, 8'd1,   1'b0, 3'd1},  // R3
        {2'b00, 1'b0, 8'd0,   1'b0, 3'd1},  // R3
        {2'b10, 1'b0, 8'd255, 1'b0, 3'd1},  // R9 down wrap
        {2'b00, 1'b0, 8'd0,   1'b1, 3'd1},  // R9 up wrap
        {2'b01, 1'b0, 8'd1,   1'b1, 3'd1},
        {2'b11, 1'b0, 8'd2,   1'b1, 3'd1},
        {2'b11, 1'b1, 8'd0,   1'b1, 3'd0},  // R7 rising edge
        {2'b10, 1'b1, 8'd1,   1'b1, 3'd1},  // R7 held high
        {2'b00, 1'b0, 8'd2,   1'b1, 3'd1}   // R7 falling edge
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
    logic [POS_W-1:0] pos;
    logic             dir, step_valid, jump_err;

    int checks = 0;
    int errors = 0;
    int strobe_total = 0;
    int wide_strobes = 0;
    bit prev_sv = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    qdec_x4_top #(.POS_W(POS_W), .SYNC_STAGES(2), .DEB_CYCLES(DEB)) dut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .pos(pos), .dir(dir), .step_valid(step_valid), .jump_err(jump_err)
    );

    // Strobe monitor: count pulses and pulses longer than one clock (R5).
    always @(negedge clk) begin
        if (rst_n && step_valid) strobe_total <= strobe_total + 1;
        if (rst_n && step_valid && prev_sv) wide_strobes <= wide_strobes + 1;
        prev_sv <= step_valid;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int s0;
        do_reset();
        chk("R1 pos", int'(pos), 0);
        chk("R1 dir", int'(dir), 0);
        chk("R1 step_valid", int'(step_valid), 0);
        chk("R1 jump_err", int'(jump_err), 0);

        for (int i = 0; i < NV; i++) begin
            s0 = strobe_total;
            @(negedge clk);
            {enc_a, enc_b} = VEC[i][14:13];
            enc_idx = VEC[i][12];
            settle();
            chk($sformatf("R2/R3/R7/R9 pos vec%0d", i), int'(pos), int'(VEC[i][11:4]));
            chk($sformatf("R5 dir vec%0d", i), int'(dir), int'(VEC[i][3]));
            chk($sformatf("R5 strobes vec%0d", i), strobe_total - s0, int'(VEC[i][2:0]));
        end
        chk("R5 strobe width", wide_strobes, 0);

        // R8: glitch on A shorter than the debounce window.
        s0 = strobe_total;
        @(negedge clk); enc_a = 1'b1;
        repeat (DEB - 2) @(negedge clk);
        enc_a = 1'b0;
        settle();
        chk("R8 pos after glitch", int'(pos), 2);
        chk("R8 strobes after glitch", strobe_total - s0, 0);

        // R6: both channels change together, 00 -> 11.
        s0 = strobe_total;
        @(negedge clk); enc_a = 1'b1; enc_b = 1'b1;
        settle();
        chk("R6 pos unchanged", int'(pos), 2);
        chk("R6 no strobe", strobe_total - s0, 0);
        chk("R6 jump_err set", int'(jump_err), 1);

        // R6: flag stays set across a good step (11 -> 10 counts up).
        @(negedge clk); enc_b = 1'b0;
        settle();
        chk("R2 step after jump", int'(pos), 3);
        chk("R6 jump_err sticky", int'(jump_err), 1);

        // R1: synchronous reset mid-run clears everything.
        enc_a = 1'b0; enc_b = 1'b0;
        do_reset();
        chk("R1 pos after reset", int'(pos), 0);
        chk("R1 jump_err after reset", int'(jump_err), 0);
        chk("R1 dir after reset", int'(dir), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule